// File: doc/BRIEF.md
# Down-Counting Interval Timer with Maskable Interrupt

This block is an 8-bit interval timer reached over a byte-wide register bus. Software loads a start value into the count register. The counter then steps down by one on every clock cycle where the tick-enable input is high. A prescaler or any other tick source outside the block drives that input. When a tick takes the counter from one to zero, a sticky interrupt flag is raised. The counter does not stop there: it wraps around and keeps counting.

The control register holds two bits, the flag and a mask. The mask has an inverted sense: a 1 blocks the interrupt request and a 0 lets it through. Software clears the flag by writing 0 to the flag bit. Writing 1 to that bit does nothing. Software can read the running count at any time, and the read has no effect on counting. The bus read path is combinational from the address.

Top module: `downTimer`

## Requirements
- R1: After reset the count reads 0x00, the control register reads 0x40 (flag 0, mask 1) and irqReq is low.
- R2: A write to address 0x08 loads the written byte into the counter on that clock edge. If a tick arrives in the same cycle, the load wins.
- R3: The counter decreases by exactly one on each cycle where tickEn is high and no load occurs. On every other cycle it holds its value.
- R4: With address 0x08 presented and no write, busRdData shows the current count. Repeated reads leave the count unchanged.
- R5: A tick at count 0x00 makes the count 0xFF, and counting continues from there.
- R6: Bit 7 of the control register (address 0x09) is the flag. It becomes 1 in the cycle after a tick moves the count from 0x01 to 0x00. It stays 1 through later ticks and wraps.
- R7: A control write with bit 7 = 0 clears the flag. A control write with bit 7 = 1 leaves it unchanged. If the hardware sets the flag in the same cycle as a software clear, the flag ends up set.
- R8: Bit 6 of the control register is the mask, loaded by every control write. irqReq is high exactly when the flag is 1 and the mask is 0. Bits 5..0 of the control register read as 0.
- R9: Writes to any address other than 0x08 and 0x09 change neither the count nor the control register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Count-enable tick, one decrement per high cycle |
| busAddr | input | 8 | Register address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr (combinational) |
| irqReq | output | 1 | Interrupt request, flag AND NOT mask |

## Verification
The counter is driven in four ways:
- Idle cycles with no tick show that ticks alone move the count.
- Bursts of ticks step the count down to one and then to zero. These show that the flag rises only on the step into zero.
- A tick at zero shows the wrap, and that the wrap leaves the flag untouched.
- Collisions in the same cycle (a load against a tick, and a hardware set against a software clear) show which source has priority.

Control writes with each combination of flag bit and mask bit separate clear-versus-keep from mask-on-versus-mask-off at irqReq. A write to an unused address confirms that the decode is exact.

// File: rtl/downTimerPkg.sv
package downTimerPkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] COUNT_ADDR = 8'h08;
  localparam logic [ADDR_W-1:0] CTRL_ADDR  = 8'h09;
  localparam int unsigned FLAG_BIT = 7;
  localparam int unsigned MASK_BIT = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCount;
  } pathStrobe_t;
endpackage

// File: rtl/downTimerPath.sv
module downTimerPath
  import downTimerPkg::*;
#(
  parameter int unsigned CNT_W = DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  pathStrobe_t      strobe,
  input  logic [CNT_W-1:0] loadData,
  output logic [CNT_W-1:0] count,
  output logic             hitZero
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ALL1 = '1;

  logic stepNow;
  assign stepNow = tickEn && !strobe.loadCount;
  assign hitZero = stepNow && (count == ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 count <= ZERO;
    else if (strobe.loadCount) count <= loadData;
    else if (tickEn)           count <= count - ONE;
  end

  // R2
  load_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCount |=> count == $past(loadData));
  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !strobe.loadCount) |=> $stable(count));
  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepNow && count == ZERO) |=> count == ALL1);
endmodule

// File: rtl/downTimerCtrl.sv
module downTimerCtrl
  import downTimerPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              flagWrBit,
  input  logic              maskWrBit,
  input  logic [DATA_W-1:0] count,
  input  logic              hitZero,
  output pathStrobe_t       strobe,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqReq
);
  logic wrCtrl;
  logic swClear;
  logic flag;
  logic mask;

  assign wrCtrl           = busWrEn && (busAddr == CTRL_ADDR);
  assign strobe.loadCount = busWrEn && (busAddr == COUNT_ADDR);
  assign swClear          = wrCtrl && !flagWrBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        flag <= 1'b0;
    else if (hitZero) flag <= 1'b1;
    else if (swClear) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       mask <= 1'b1;
    else if (wrCtrl) mask <= maskWrBit;
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == COUNT_ADDR) begin
      busRdData = count;
    end else if (busAddr == CTRL_ADDR) begin
      busRdData[FLAG_BIT] = flag;
      busRdData[MASK_BIT] = mask;
    end
  end

  assign irqReq = flag && !mask;

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitZero |=> flag);
  // R7
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !swClear) |=> flag);
  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swClear && !hitZero) |=> !flag);
endmodule

// File: rtl/downTimer.sv
module downTimer
  import downTimerPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqReq
);
  pathStrobe_t       strobe;
  logic [DATA_W-1:0] count;
  logic              hitZero;

  downTimerCtrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .flagWrBit (busWrData[FLAG_BIT]),
    .maskWrBit (busWrData[MASK_BIT]),
    .count     (count),
    .hitZero   (hitZero),
    .strobe    (strobe),
    .busRdData (busRdData),
    .irqReq    (irqReq)
  );

  downTimerPath #(.CNT_W(DATA_W)) path_i (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .strobe   (strobe),
    .loadData (busWrData),
    .count    (count),
    .hitZero  (hitZero)
  );

  // R8
  mask_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == CTRL_ADDR && busWrData[MASK_BIT]) |=> !irqReq);
endmodule

// File: tb/downTimer_tb_top.sv
`timescale 1ns/1ps
module downTimer_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic       irqReq;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  downTimer dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .irqReq(irqReq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [7:0] v);
    busAddr = a;
    #1 v = busRdData;
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [7:0] d, input logic tk);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1; tickEn = tk;
    @(negedge clk);
    busWrEn = 1'b0; tickEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic expectState(input string req, input logic [7:0] cnt,
                             input logic [7:0] ctl, input logic irq);
    logic [7:0] v;
    rdReg(8'h08, v); check(req, v, cnt);
    rdReg(8'h09, v); check(req, v, ctl);
    check(req, {7'd0, irqReq}, {7'd0, irq});
  endtask

  task automatic testReset();
    expectState("R1 reset", 8'h00, 8'h40, 1'b0);
  endtask

  task automatic testLoadHold();
    logic [7:0] v;
    wrReg(8'h08, 8'h05, 1'b0);
    rdReg(8'h08, v); check("R2 load", v, 8'h05);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rdReg(8'h08, v); check("R3 R4 hold/read", v, 8'h05);
    end
  endtask

  task automatic testCountDown();
    logic [7:0] v;
    busAddr = 8'h08;
    @(negedge clk);
    tickEn = 1'b1;
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      #1 v = busRdData;
      check("R3 R4 step", v, 8'(5 - i));
    end
    tickEn = 1'b0;
    expectState("R6 no flag yet", 8'h02, 8'h40, 1'b0);
    ticks(1);
    expectState("R6 at one", 8'h01, 8'h40, 1'b0);
    ticks(1);
    expectState("R6 flag set masked", 8'h00, 8'hC0, 1'b0);
  endtask

  task automatic testMaskWrap();
    wrReg(8'h09, 8'h80, 1'b0);
    expectState("R7 R8 keep+unmask", 8'h00, 8'h80, 1'b1);
    ticks(1);
    expectState("R5 wrap", 8'hFF, 8'h80, 1'b1);
    ticks(2);
    expectState("R5 continue", 8'hFD, 8'h80, 1'b1);
    wrReg(8'h09, 8'hC0, 1'b0);
    expectState("R8 mask blocks", 8'hFD, 8'hC0, 1'b0);
    wrReg(8'h09, 8'h00, 1'b0);
    expectState("R7 clear", 8'hFD, 8'h00, 1'b0);
  endtask

  task automatic testCollisions();
    wrReg(8'h08, 8'h01, 1'b0);
    wrReg(8'h09, 8'h00, 1'b1);
    expectState("R7 set beats clear", 8'h00, 8'h80, 1'b1);
    wrReg(8'h09, 8'h00, 1'b0);
    wrReg(8'h08, 8'h20, 1'b1);
    expectState("R2 load beats tick", 8'h20, 8'h00, 1'b0);
  endtask

  task automatic testOtherAddr();
    logic [7:0] v;
    wrReg(8'h0A, 8'hFF, 1'b0);
    wrReg(8'h00, 8'h00, 1'b0);
    expectState("R9 other addr", 8'h20, 8'h00, 1'b0);
    rdReg(8'h0A, v); check("R9 unused reads zero", v, 8'h00);
  endtask

  initial begin
    #4_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLoadHold();
    testCountDown();
    testMaskWrap();
    testCollisions();
    testOtherAddr();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule